// File: doc/BRIEF.md
# System Counter-Timer with Per-Processor Mode Control

This block is the chip-level counter-timer of a multiprocessor timer cluster. It counts in fixed steps of 0x200 (one step every `TICK_CYCLES` clocks, 500 ns at the intended clock), wraps at a programmable limit and raises its own interrupt when the limit is reached. A limit of zero turns it into a free-running counter. The limit can be loaded either with a count restart or without touching the count. Reading the limit word acknowledges the interrupt.

The block also owns a per-processor mode word with one bit per processor timer. A set bit places that processor's timer in user mode, a free-running counter that raises no interrupt. A clear bit keeps it in interrupting system mode. The mode bits drive level outputs to the processor timers, which are separate instances. Every bit that changes on a write produces a one-cycle restart pulse, so that timer is stopped, reloaded and restarted.

Top module: `sys_timer_mctl`

## Requirements
- R1: After reset the limit reads 0 (free-run), the count reads 0, the mode word reads 0, `sys_irq` is low, `cpu_user_mode` is all zero and `cpu_restart` is all zero.
- R2: The count advances by 0x200 once every `TICK_CYCLES` clocks, measured from reset or from a restarting limit write. Bits 8..0 of the count word (index 1) always read zero.
- R3: With a nonzero limit of L steps (limit value bits 30..9), the tick that would bring the count to L or above instead sets it to 0. The same tick sets the reached flag, which is bit 31 of the index 1 word, and raises `sys_irq`. Reading index 1 does not clear the flag.
- R4: Reading index 0 returns the stored limit (bits 30..9, all other bits zero) and clears the reached flag and `sys_irq` at that clock edge. If a terminal tick falls on the same edge, the flag stays set.
- R5: Writing index 0 stores `wdata[30:9]` as the limit. It also resets the count and the step prescaler to zero and clears the reached flag. This write takes priority over a tick on the same edge.
- R6: Writing index 2 stores `wdata[30:9]` as the limit and leaves the count, prescaler and reached flag unchanged.
- R7: With limit 0 the counter runs freely up to 0x7FFFFE00, then wraps to 0 and sets the reached flag. Before that point it never sets the flag.
- R8: Writing index 4 stores `wdata[NCPU-1:0]` as the mode word. Higher bits are dropped. Index 4 reads the mode word zero-extended. `cpu_user_mode` equals the mode word from the clock after the write.
- R9: `cpu_restart` is combinational. During the cycle of an index 4 write it equals the new masked mode bits XOR the old mode word. It is all zero in every other cycle.
- R10: Index 3 and indices 5 to 7 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_index | input | 3 | Word index of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when no read is active |
| sys_irq | output | 1 | System timer interrupt (level, equals the reached flag) |
| cpu_user_mode | output | NCPU | Per-processor user-mode select |
| cpu_restart | output | NCPU | One-cycle restart pulse per processor timer |

## Verification
Two events can land on the same clock edge: the terminal tick, which sets the reached flag, and the acknowledge read of index 0, which clears it. The bench restarts the count with a write to index 0 and counts edges from that write. It then places an index 0 read so that it is sampled on exactly the edge of the second terminal tick. It judges the result by `sys_irq`, which must still be high in the following cycle, and then by a further read that must clear it. A similar count of edges places the index 2 write between ticks, to show that the count carries on.

// File: rtl/sys_timer_pkg.sv
package sys_timer_pkg;

    localparam int CNT_W = 22;  // count steps, bits 30..9 of the words
    localparam int LSB   = 9;

    localparam logic [2:0] IDX_LIMIT_RST = 3'd0;
    localparam logic [2:0] IDX_COUNT     = 3'd1;
    localparam logic [2:0] IDX_LIMIT_KEEP = 3'd2;
    localparam logic [2:0] IDX_MODE      = 3'd4;

    typedef struct packed {
        logic [CNT_W-1:0] lim;
        logic [CNT_W-1:0] cnt;
        logic             reached;
    } cnt_state_t;

endpackage

// File: rtl/sys_timer_prescale.sv
module sys_timer_prescale #(
    parameter int TICK_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PW = $clog2(TICK_CYCLES + 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;

    assign tick = (pre_q.cnt == PW'(TICK_CYCLES - 1));

    always_comb begin
        pre_d = pre_q;
        if (restart || tick) begin
            pre_d.cnt = '0;
        end else begin
            pre_d.cnt = pre_q.cnt + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end
endmodule

// File: rtl/sys_timer_core.sv
module sys_timer_core
    import sys_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_rst,
    input  logic             load_keep,
    input  logic             ack,
    input  logic [CNT_W-1:0] new_lim,
    output logic [CNT_W-1:0] lim,
    output logic [CNT_W-1:0] cnt,
    output logic             reached
);
    cnt_state_t st_d, st_q;
    logic [CNT_W:0] step_nxt;
    logic           terminal;

    always_comb begin
        step_nxt = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
        if (st_q.lim == '0) begin
            terminal = (st_q.cnt == '1);
        end else begin
            terminal = (step_nxt >= {1'b0, st_q.lim});
        end
    end

    always_comb begin
        st_d = st_q;
        if (ack) begin
            st_d.reached = 1'b0;
        end
        if (tick) begin
            if (terminal) begin
                st_d.cnt     = '0;
                st_d.reached = 1'b1;
            end else begin
                st_d.cnt = step_nxt[CNT_W-1:0];
            end
        end
        if (load_keep) begin
            st_d.lim = new_lim;
        end
        if (load_rst) begin
            st_d.lim     = new_lim;
            st_d.cnt     = '0;
            st_d.reached = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lim     = st_q.lim;
    assign cnt     = st_q.cnt;
    assign reached = st_q.reached;
endmodule

// File: rtl/sys_timer_mode.sv
module sys_timer_mode #(
    parameter int NCPU = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [NCPU-1:0] wbits,
    output logic [NCPU-1:0] mode,
    output logic [NCPU-1:0] restart
);
    typedef struct packed {
        logic [NCPU-1:0] bits;
    } mode_t;

    mode_t md_d, md_q;

    always_comb begin
        md_d    = md_q;
        restart = '0;
        if (wr) begin
            md_d.bits = wbits;
            restart   = wbits ^ md_q.bits;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            md_q <= '0;
        end else begin
            md_q <= md_d;
        end
    end

    assign mode = md_q.bits;
endmodule

// File: rtl/sys_timer_mctl.sv
module sys_timer_mctl
    import sys_timer_pkg::*;
#(
    parameter int NCPU        = 4,
    parameter int TICK_CYCLES = 100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_valid,
    input  logic            bus_write,
    input  logic [2:0]      bus_index,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    output logic            sys_irq,
    output logic [NCPU-1:0] cpu_user_mode,
    output logic [NCPU-1:0] cpu_restart
);
    localparam int PAD = 32 - NCPU;

    logic             wr_lim_rst, wr_lim_keep, wr_mode, rd_ack, rd_act;
    logic             tick;
    logic [CNT_W-1:0] lim, cnt;
    logic             reached;

    assign rd_act      = bus_valid && !bus_write;
    assign wr_lim_rst  = bus_valid && bus_write && (bus_index == IDX_LIMIT_RST);
    assign wr_lim_keep = bus_valid && bus_write && (bus_index == IDX_LIMIT_KEEP);
    assign wr_mode     = bus_valid && bus_write && (bus_index == IDX_MODE);
    assign rd_ack      = rd_act && (bus_index == IDX_LIMIT_RST);

    sys_timer_prescale #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_lim_rst),
        .tick    (tick)
    );

    sys_timer_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load_rst  (wr_lim_rst),
        .load_keep (wr_lim_keep),
        .ack       (rd_ack),
        .new_lim   (bus_wdata[LSB +: CNT_W]),
        .lim       (lim),
        .cnt       (cnt),
        .reached   (reached)
    );

    sys_timer_mode #(.NCPU(NCPU)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr_mode),
        .wbits   (bus_wdata[NCPU-1:0]),
        .mode    (cpu_user_mode),
        .restart (cpu_restart)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_act) begin
            case (bus_index)
                IDX_LIMIT_RST: bus_rdata = {1'b0, lim, {LSB{1'b0}}};
                IDX_COUNT:     bus_rdata = {reached, cnt, {LSB{1'b0}}};
                IDX_MODE:      bus_rdata = {{PAD{1'b0}}, cpu_user_mode};
                default:       bus_rdata = '0;
            endcase
        end
    end

    assign sys_irq = reached;
endmodule

// File: rtl/sys_timer_mctl_chk.sv
module sys_timer_mctl_chk #(
    parameter int NCPU = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_valid,
    input logic            bus_write,
    input logic [2:0]      bus_index,
    input logic [31:0]     bus_wdata,
    input logic [31:0]     bus_rdata,
    input logic            sys_irq,
    input logic [NCPU-1:0] cpu_user_mode,
    input logic [NCPU-1:0] cpu_restart
);
    logic mode_wr;
    assign mode_wr = bus_valid && bus_write && (bus_index == 3'd4);

    assert_restart_only_on_mode_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_restart != '0) |-> mode_wr);

    assert_mode_follows_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (cpu_user_mode == $past(bus_wdata[NCPU-1:0])));

    assert_mode_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr |=> $stable(cpu_user_mode));

    assert_count_low_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_index == 3'd1) |-> (bus_rdata[8:0] == 9'd0));

    assert_restart_write_clears_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_index == 3'd0) |=> !sys_irq);

    assert_unused_index_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && (bus_index == 3'd3 || bus_index > 3'd4)) |-> (bus_rdata == 32'd0));

    assert_limit_read_bit31_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_index == 3'd0) |-> (bus_rdata[31] == 1'b0));
endmodule

bind sys_timer_mctl sys_timer_mctl_chk #(.NCPU(NCPU)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_valid     (bus_valid),
    .bus_write     (bus_write),
    .bus_index     (bus_index),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .sys_irq       (sys_irq),
    .cpu_user_mode (cpu_user_mode),
    .cpu_restart   (cpu_restart)
);

// File: tb/sys_timer_mctl_tb.sv
`timescale 1ns/1ps
module sys_timer_mctl_tb;
    localparam int NCPU = 4;
    localparam int T    = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_valid = 1'b0;
    logic            bus_write = 1'b0;
    logic [2:0]      bus_index = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            sys_irq;
    logic [NCPU-1:0] cpu_user_mode;
    logic [NCPU-1:0] cpu_restart;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int e0 = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sys_timer_mctl #(.NCPU(NCPU), .TICK_CYCLES(T)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_index(bus_index), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sys_irq(sys_irq), .cpu_user_mode(cpu_user_mode), .cpu_restart(cpu_restart)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // all tasks start and end at a negedge
    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_index = idx; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        if (idx == 3'd0) e0 = cyc;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] v);
        bus_valid = 1'b1; bus_write = 1'b0; bus_index = idx;
        #1 v = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic wait_m(input int m);
        while ((cyc - e0) < m) @(negedge clk);
    endtask

    task automatic t_reset();
        rd(3'd0, rv); chk("R1 limit", rv, 32'h0);
        rd(3'd1, rv); chk("R1 count", rv, 32'h0);
        rd(3'd4, rv); chk("R1 mode", rv, 32'h0);
        chk("R1 irq", {31'd0, sys_irq}, 32'h0);
        chk("R1 user_mode", 32'(cpu_user_mode), 32'h0);
        chk("R1 restart", 32'(cpu_restart), 32'h0);
    endtask

    task automatic t_limit_and_collision();
        wr(3'd0, 32'h0000_07FF);          // limit 3 steps, low bits dropped
        rd(3'd1, rv); chk("R5 count reset", rv, 32'h0);
        wait_m(2*T);
        rd(3'd1, rv); chk("R2 count step", rv, 32'h0000_0400);
        wait_m(3*T - 1);
        rd(3'd1, rv); chk("R3 before limit", rv, 32'h0000_0400);
        rd(3'd1, rv); chk("R3 wrap and reached", rv, 32'h8000_0000);
        #1 chk("R3 irq high", {31'd0, sys_irq}, 32'h1);
        rd(3'd1, rv); chk("R3 idx1 read keeps flag", rv, 32'h8000_0000);
        rd(3'd0, rv); chk("R4 limit readback", rv, 32'h0000_0600);
        #1 chk("R4 ack lowers irq", {31'd0, sys_irq}, 32'h0);
        wait_m(6*T - 1);
        rd(3'd0, rv);                     // sampled on the terminal edge
        #1 chk("R4 terminal tick beats ack", {31'd0, sys_irq}, 32'h1);
        rd(3'd0, rv);
        #1 chk("R4 second ack clears", {31'd0, sys_irq}, 32'h0);
        wait_m(7*T + 2);
        chk("R3 irq stays low mid-period", {31'd0, sys_irq}, 32'h0);
        wr(3'd0, 32'h0000_0600);
        rd(3'd1, rv); chk("R5 restart clears count", rv, 32'h0);
    endtask

    task automatic t_norst();
        wr(3'd0, 32'h0);                  // free run
        wait_m(2*T);
        wr(3'd2, 32'h0000_1000);          // limit 8 steps, count kept
        rd(3'd1, rv); chk("R6 count kept", rv, 32'h0000_0400);
        rd(3'd0, rv); chk("R6 limit loaded", rv, 32'h0000_1000);
        wait_m(8*T - 1);
        rd(3'd1, rv); chk("R6 count before new limit", rv, 32'h0000_0E00);
        rd(3'd1, rv); chk("R6 wrap at new limit", rv, 32'h8000_0000);
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, rv); chk("R5 limit masked", rv, 32'h7FFF_FE00);
    endtask

    task automatic t_freerun();
        wr(3'd0, 32'h0);
        wait_m(20*T);
        rd(3'd1, rv); chk("R7 free run no flag", rv, 32'h0000_2800);
        chk("R7 irq low", {31'd0, sys_irq}, 32'h0);
    endtask

    task automatic t_mode();
        bus_valid = 1'b1; bus_write = 1'b1; bus_index = 3'd4; bus_wdata = 32'h5;
        #1 chk("R9 restart on first write", 32'(cpu_restart), 32'h5);
        @(posedge clk); @(negedge clk); bus_valid = 1'b0;
        chk("R9 pulse one cycle", 32'(cpu_restart), 32'h0);
        chk("R8 user mode out", 32'(cpu_user_mode), 32'h5);
        rd(3'd4, rv); chk("R8 mode readback", rv, 32'h5);
        bus_valid = 1'b1; bus_write = 1'b1; bus_index = 3'd4; bus_wdata = 32'hFFFF_FFF6;
        #1 chk("R9 only changed bits", 32'(cpu_restart), 32'h3);
        @(posedge clk); @(negedge clk); bus_valid = 1'b0;
        rd(3'd4, rv); chk("R8 upper bits masked", rv, 32'h6);
        bus_valid = 1'b1; bus_write = 1'b1; bus_index = 3'd4; bus_wdata = 32'h6;
        #1 chk("R9 no change no pulse", 32'(cpu_restart), 32'h0);
        @(posedge clk); @(negedge clk); bus_valid = 1'b0;
    endtask

    task automatic t_unused();
        wr(3'd0, 32'h0000_0C00);
        rd(3'd3, rv); chk("R10 idx3 reads zero", rv, 32'h0);
        for (int i = 5; i < 8; i++) begin
            rd(3'(i), rv); chk("R10 high idx reads zero", rv, 32'h0);
        end
        for (int i = 3; i < 8; i++) begin
            if (i != 4) begin
                bus_valid = 1'b1; bus_write = 1'b1; bus_index = 3'(i); bus_wdata = 32'hFFFF_FFFF;
                #1 chk("R10 no restart", 32'(cpu_restart), 32'h0);
                @(posedge clk); @(negedge clk); bus_valid = 1'b0;
            end
        end
        rd(3'd0, rv); chk("R10 limit untouched", rv, 32'h0000_0C00);
        rd(3'd4, rv); chk("R10 mode untouched", rv, 32'h6);
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_limit_and_collision();
        t_norst();
        t_freerun();
        t_mode();
        t_unused();
        finish_run();
    end
endmodule